// File: doc/BRIEF.md
# Token-Sequenced I2C Master

This block is an I2C bus master that software programs with a short script rather than with one command per byte. Software loads a packed list of up to sixteen 4-bit tokens, a target address and up to eight bytes of outgoing data. It then sets a trigger bit. The engine walks the list on its own and produces START and STOP conditions, address and data bytes, and acknowledge bits. Incoming bytes are collected into two read words. At the end of the run the engine pulses an interrupt.

Both bus lines are open-drain. The block pulls SCL or SDA low by asserting an output enable, and it reads back the resolved SDA level. Bus timing comes from a 12-bit divider. Every bit, START and STOP element is built from four quarter phases, and each quarter lasts `divider` input clocks. A divider value of 0 behaves as 1. Between elements the engine spends one extra clock, with SCL released, to fetch the next token.

Top module: `tokbus_i2c`

## Requirements
- R1: After reset, every readable register reads 0, both output enables are 0 and the interrupt is 0. Register word indices on `reg_addr` are: 0 control, 1 target address, 2 tokens 0..7, 3 tokens 8..15, 4 write bytes 0..3, 5 write bytes 4..7, 6 read bytes 0..3, 7 read bytes 4..7.
- R2: A run begins only when a write to word 0 changes control bit 0 from 0 to 1. Writing 1 while the bit is already 1 starts nothing. Control bit 2 reads 1 while a run is executing and 0 otherwise.
- R3: Tokens are 4 bits wide. Token i sits at bits 4i+3:4i of the 64-bit value {word 3, word 2} and is executed in increasing i. Codes: 0 end, 1 START, 2 address with write, 3 address with read, 4 data, 5 last read data, 6 STOP. Codes 7 to 15 also end the run, and the run ends after token 15 in any case.
- R4: Codes 2 and 3 transmit bits 7:1 of the target-address register, most significant bit first, followed by a direction bit. That bit is 0 for code 2 and 1 for code 3, whatever bit 0 of the register holds.
- R5: After code 2, or at the start of a run, code 4 transmits the next write byte. Byte k is bits 8k+7:8k of {word 5, word 4}. The byte pointer restarts at 0 on every run and wraps from 7 to 0.
- R6: After code 3, code 4 receives a byte and answers ACK, and code 5 receives a byte and answers NACK. Received byte k lands in bits 8k+7:8k of {word 7, word 6}, with k restarting at 0 on each run.
- R7: When a transmitted byte gets no acknowledge and control bit 1 is 0, the engine sets control bit 3, sends STOP and ends the run. When control bit 1 is 1, the run continues. Bit 3 clears when the next run begins.
- R8: The divider is {control bits 29:28, control bits 21:12}. One SCL period inside a byte lasts 4 × divider clocks.
- R9: A START drops SDA while SCL is high. A STOP releases SDA while SCL is high. At every other point of a run, SDA changes only while SCL is low.
- R10: The interrupt is a single-cycle pulse at the end of every run, whether the run completes, fails or is aborted.
- R11: Writing 0 to control bit 0 during a run stops it on the next clock and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | End-of-run pulse |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
A token index that is off by one, or an END that is missed, changes the number of bytes and STOP conditions the bus target sees, and this shows up before the interrupt of that same run. A byte pointer or direction flag that drifts appears as a wrong byte on the wire within one byte time, or as a wrong lane in the read words once the run ends. A quarter-phase counter that runs wrong shows as an SCL period that is not exactly four divider units between the first two data bits. A misplaced SDA update shows as an extra START or STOP seen by the target, inside the same bit.

// File: rtl/tokbus_i2c.sv
module tokbus_i2c (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_BIT, S_STOP} st_t;
  localparam logic [3:0] T_START = 4'd1, T_AW = 4'd2, T_AR = 4'd3,
                         T_DATA = 4'd4, T_LAST = 4'd5, T_STOP = 4'd6;

  st_t         st;
  logic        go, ack_ign, err, rx, ack_out, rctx, nack, fail, sda_drv;
  logic [11:0] div, qcnt;
  logic [7:0]  tgt, sh;
  logic [63:0] tok, wd, rd;
  logic [4:0]  tidx;
  logic [2:0]  wptr, rptr;
  logic [1:0]  q;
  logic [3:0]  bcnt;

  logic        busy, cond_phase;
  wire         ctl_wr = reg_wr && (reg_addr == 3'd0);
  wire         launch = ctl_wr && reg_wdata[0] && !go;
  wire         abort  = ctl_wr && !reg_wdata[0] && busy;
  wire  [11:0] divm1  = (div == 12'd0) ? 12'd0 : div - 12'd1;
  wire         tick   = (qcnt == divm1);
  wire  [3:0]  tk     = tok[{tidx[3:0], 2'b00} +: 4];
  wire  [7:0]  wbyte  = wd[{wptr, 3'b000} +: 8];

  assign busy       = (st != S_IDLE);
  assign cond_phase = (st == S_START) || (st == S_STOP);
  assign scl_oe     = (st == S_START || st == S_BIT || st == S_STOP) && !q[1];
  assign sda_oe     = sda_drv;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {2'b00, div[11:10], 6'b0, div[9:0], 8'b0, err, busy, ack_ign, go};
      3'd1:    reg_rdata = {24'b0, tgt};
      3'd2:    reg_rdata = tok[31:0];
      3'd3:    reg_rdata = tok[63:32];
      3'd4:    reg_rdata = wd[31:0];
      3'd5:    reg_rdata = wd[63:32];
      3'd6:    reg_rdata = rd[31:0];
      default: reg_rdata = rd[63:32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go <= 1'b0; ack_ign <= 1'b0; err <= 1'b0; irq <= 1'b0;
      rx <= 1'b0; ack_out <= 1'b0; rctx <= 1'b0; nack <= 1'b0; fail <= 1'b0;
      sda_drv <= 1'b0; div <= '0; qcnt <= '0; tgt <= '0; sh <= '0;
      tok <= '0; wd <= '0; rd <= '0; tidx <= '0; wptr <= '0; rptr <= '0;
      q <= '0; bcnt <= '0;
    end else begin
      irq <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            go <= reg_wdata[0]; ack_ign <= reg_wdata[1];
            div <= {reg_wdata[29:28], reg_wdata[21:12]};
          end
          3'd1: tgt <= reg_wdata[7:0];
          3'd2: tok[31:0] <= reg_wdata;
          3'd3: tok[63:32] <= reg_wdata;
          3'd4: wd[31:0] <= reg_wdata;
          3'd5: wd[63:32] <= reg_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        st <= S_FETCH; tidx <= '0; wptr <= '0; rptr <= '0;
        rctx <= 1'b0; err <= 1'b0; fail <= 1'b0; sda_drv <= 1'b0;
      end else if (abort) begin
        st <= S_IDLE; sda_drv <= 1'b0; irq <= 1'b1;
      end else if (st == S_FETCH) begin
        qcnt <= '0; q <= '0; bcnt <= '0; tidx <= tidx + 5'd1;
        if (tidx[4]) begin
          st <= S_IDLE; irq <= 1'b1;
        end else begin
          case (tk)
            T_START: st <= S_START;
            T_AW, T_AR: begin
              sh <= {tgt[7:1], tk[0]}; rx <= 1'b0; rctx <= tk[0]; st <= S_BIT;
            end
            T_DATA: begin
              rx <= rctx; ack_out <= 1'b1; st <= S_BIT;
              if (!rctx) begin sh <= wbyte; wptr <= wptr + 3'd1; end
            end
            T_LAST: begin rx <= 1'b1; ack_out <= 1'b0; st <= S_BIT; end
            T_STOP: st <= S_STOP;
            default: begin st <= S_IDLE; irq <= 1'b1; end
          endcase
        end
      end else if (st != S_IDLE) begin
        if (tick) begin qcnt <= '0; q <= q + 2'd1; end
        else qcnt <= qcnt + 12'd1;
        if (tick) begin
          case (st)
            S_START: begin
              if (q == 2'd0) sda_drv <= 1'b0;
              if (q == 2'd2) sda_drv <= 1'b1;
              if (q == 2'd3) st <= S_FETCH;
            end
            S_STOP: begin
              if (q == 2'd0) sda_drv <= 1'b1;
              if (q == 2'd2) sda_drv <= 1'b0;
              if (q == 2'd3) begin
                if (fail) begin st <= S_IDLE; irq <= 1'b1; end
                else st <= S_FETCH;
              end
            end
            default: begin
              if (q == 2'd0)
                sda_drv <= (bcnt == 4'd8) ? (rx && ack_out) : (!rx && !sh[7]);
              if (q == 2'd2) begin
                if (bcnt == 4'd8) nack <= sda_in;
                else if (rx) sh <= {sh[6:0], sda_in};
              end
              if (q == 2'd3) begin
                if (bcnt != 4'd8) begin
                  bcnt <= bcnt + 4'd1;
                  if (!rx) sh <= {sh[6:0], 1'b0};
                end else if (rx) begin
                  rd[{rptr, 3'b000} +: 8] <= sh; rptr <= rptr + 3'd1; st <= S_FETCH;
                end else if (nack && !ack_ign) begin
                  err <= 1'b1; fail <= 1'b1; st <= S_STOP;
                end else st <= S_FETCH;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tokbus_i2c_chk.sv
module tokbus_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       wbit0,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       go,
  input logic       err,
  input logic       cond_phase
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && wbit0 && !go |=> busy);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_end_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && !wbit0 && busy |=> !busy && !scl_oe && !sda_oe);

  p_sda_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)
    |-> cond_phase);

  p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);
endmodule

bind tokbus_i2c tokbus_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wbit0(reg_wdata[0]), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .go(go), .err(err), .cond_phase(cond_phase)
);

// File: tb/tokbus_i2c_test.sv
module tokbus_i2c_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, scl_oe, sda_oe;
  logic        slv_drv = 1'b0;
  wire         scl = !scl_oe;
  wire         sda = !(sda_oe || slv_drv);

  always #(CLK_PERIOD/2) clk = ~clk;

  tokbus_i2c uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda));

  int total = 0, bad = 0;
  bit done = 0;

  // bus target model state
  int bitc = 0, nrx = 0, nmack = 0, ns = 0, np = 0, nfall = 0, nirq = 0, sidx = 0;
  int nack_at = -1, dbl_irq = 0;
  longint cyc = 0;
  longint fall_t [0:3];
  logic [7:0] ssh = '0, cur = '0;
  logic [7:0] rxb [0:31];
  logic       mack [0:31];
  logic [7:0] src [0:15];
  logic first = 0, sread = 0, pend_read = 0, stx_off = 0, sack = 0;
  logic prev_scl = 1, prev_sda = 1, prev_irq = 0;

  always @(negedge clk) begin
    cyc++;
    if (irq) begin nirq++; if (prev_irq) dbl_irq++; end
    prev_irq = irq;
    if (prev_scl && scl && prev_sda && !sda) begin
      ns++; first = 1; bitc = 0; sread = 0; pend_read = 0; stx_off = 0; slv_drv = 0;
    end else if (prev_scl && scl && !prev_sda && sda) begin
      np++; sread = 0; slv_drv = 0;
    end else if (!prev_scl && scl) begin
      if (bitc < 8) begin
        ssh = {ssh[6:0], sda}; bitc++;
        if (bitc == 8 && !sread) begin
          if (nrx < 32) rxb[nrx] = ssh;
          if (first) begin pend_read = ssh[0]; first = 0; end
          sack = (nrx != nack_at);
          nrx++;
        end
      end else if (bitc == 8) begin
        bitc = 9;
        if (sread) begin
          if (nmack < 32) mack[nmack] = sda;
          nmack++;
          if (sda) stx_off = 1;
        end
      end
    end else if (prev_scl && !scl) begin
      if (nfall < 4) fall_t[nfall] = cyc;
      nfall++;
      if (bitc == 8) slv_drv = !sread && sack;
      else if (bitc == 9) begin
        bitc = 0;
        if (pend_read) begin sread = 1; pend_read = 0; end
        if (sread && !stx_off) begin
          cur = src[sidx[3:0]]; sidx++; slv_drv = !cur[7];
        end else slv_drv = 0;
      end else if (bitc > 0 && bitc < 8) slv_drv = sread && !stx_off && !cur[7 - bitc];
    end
    prev_scl = scl; prev_sda = sda;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrlw(input logic [11:0] dv, input logic ign, input logic g);
    return {2'b00, dv[11:10], 6'b0, dv[9:0], 8'b0, 2'b00, ign, g};
  endfunction

  function automatic logic [63:0] put(input logic [63:0] l, input int i, input logic [3:0] t);
    logic [63:0] r = l;
    r[i*4 +: 4] = t;
    return r;
  endfunction

  task automatic clear_log();
    nrx = 0; nmack = 0; ns = 0; np = 0; nfall = 0; nirq = 0; sidx = 0;
  endtask

  task automatic load(input logic [63:0] toks, input logic [63:0] wdat, input logic [7:0] tg);
    wr(3'd1, {24'b0, tg}); wr(3'd2, toks[31:0]); wr(3'd3, toks[63:32]);
    wr(3'd4, wdat[31:0]); wr(3'd5, wdat[63:32]);
  endtask

  task automatic run(input logic [63:0] toks, input logic [63:0] wdat, input logic [7:0] tg,
                     input logic [11:0] dv, input logic ign);
    load(toks, wdat, tg);
    wr(3'd0, ctrlw(dv, ign, 1'b0));
    clear_log();
    wr(3'd0, ctrlw(dv, ign, 1'b1));
    for (int i = 0; i < 60000 && nirq == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] toks, wdat, rdw;
    logic [7:0]  tg;
    logic [11:0] dv;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); chk("R1", "reset reg", d, 0);
    end
    chk("R1", "reset lines", {scl_oe, sda_oe, irq}, 0);

    // R3 R5: sixteen tokens, no END, write pointer wraps
    wdat = 64'h0807060504030201;
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    for (int i = 2; i < 15; i++) toks = put(toks, i, 4'd4);
    toks = put(toks, 15, 4'd6);
    run(toks, wdat, 8'h50, 12'd1, 1'b0);
    chk("R3", "16-token byte count", nrx, 14);
    for (int k = 0; k < 13; k++) chk("R5", "wrapped byte", rxb[k+1], wdat[(k%8)*8 +: 8]);
    chk("R3", "16-token stop", np, 1);
    chk("R10", "16-token irq", nirq, 1);

    // R3: END token stops execution
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    toks = put(toks, 2, 4'd4); toks = put(toks, 3, 4'd0); toks = put(toks, 4, 4'd6);
    run(toks, wdat, 8'h22, 12'd2, 1'b0);
    chk("R3", "end token bytes", nrx, 2);
    chk("R3", "end token no stop", np, 0);
    chk("R10", "end token irq", nirq, 1);

    // R3: undefined code behaves as END
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    toks = put(toks, 2, 4'd7); toks = put(toks, 3, 4'd4); toks = put(toks, 4, 4'd6);
    run(toks, wdat, 8'h22, 12'd1, 1'b0);
    chk("R3", "code 7 bytes", nrx, 1);
    chk("R3", "code 7 no stop", np, 0);

    // R7: NACK with ack-ignore clear
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    for (int i = 2; i < 5; i++) toks = put(toks, i, 4'd4);
    toks = put(toks, 5, 4'd6);
    nack_at = 2;
    run(toks, wdat, 8'h34, 12'd1, 1'b0);
    chk("R7", "nack bytes sent", nrx, 3);
    chk("R7", "nack auto stop", np, 1);
    rd(3'd0, d); chk("R7", "error bit", d[3], 1);
    chk("R10", "fail irq", nirq, 1);
    // R7: ack-ignore set lets the run finish, error clears
    run(toks, wdat, 8'h34, 12'd1, 1'b1);
    chk("R7", "ignore bytes sent", nrx, 4);
    rd(3'd0, d); chk("R7", "error cleared", d[3], 0);
    chk("R7", "ignore stop", np, 1);
    nack_at = -1;

    // R2: rewriting 1 while bit 0 already 1 starts nothing
    clear_log();
    wr(3'd0, ctrlw(12'd1, 1'b1, 1'b1));
    repeat (200) @(negedge clk);
    chk("R2", "no retrigger irq", nirq, 0);
    chk("R2", "no retrigger start", ns, 0);

    // R4 R6: write, repeated start, read two bytes
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    toks = put(toks, 2, 4'd4); toks = put(toks, 3, 4'd1); toks = put(toks, 4, 4'd3);
    toks = put(toks, 5, 4'd4); toks = put(toks, 6, 4'd5); toks = put(toks, 7, 4'd6);
    src[0] = 8'h3C; src[1] = 8'hC3;
    run(toks, 64'h00000000000000A5, 8'hA1, 12'd2, 1'b0);
    chk("R9", "restart starts", ns, 2);
    chk("R4", "write address", rxb[0], 8'hA0);
    chk("R5", "write byte", rxb[1], 8'hA5);
    chk("R4", "read address", rxb[2], 8'hA1);
    chk("R6", "data acked", mack[0], 0);
    chk("R6", "last nacked", mack[1], 1);
    rd(3'd6, d); chk("R6", "read lanes", d[15:0], 16'hC33C);

    // R2: status bit while running
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    toks = put(toks, 2, 4'd4); toks = put(toks, 3, 4'd6);
    load(toks, wdat, 8'h10);
    wr(3'd0, ctrlw(12'd2, 1'b0, 1'b0));
    clear_log();
    wr(3'd0, ctrlw(12'd2, 1'b0, 1'b1));
    repeat (20) @(negedge clk);
    rd(3'd0, d); chk("R2", "status busy", d[2], 1);
    for (int i = 0; i < 5000 && nirq == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(3'd0, d); chk("R2", "status idle", d[2], 0);

    // random writes: R4 R5 R8 R9 R10
    for (int t = 0; t < 10; t++) begin
      n = 1 + int'($urandom % 8);
      tg = 8'($urandom); dv = 12'(1 + $urandom % 3);
      wdat = {$urandom, $urandom};
      toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
      for (int i = 0; i < n; i++) toks = put(toks, 2 + i, 4'd4);
      toks = put(toks, 2 + n, 4'd6);
      run(toks, wdat, tg, dv, 1'b0);
      chk("R4", "rand write address", rxb[0], {tg[7:1], 1'b0});
      chk("R5", "rand write count", nrx, n + 1);
      for (int k = 0; k < n; k++) chk("R5", "rand write byte", rxb[k+1], wdat[k*8 +: 8]);
      chk("R9", "rand starts/stops", {ns[7:0], np[7:0]}, 16'h0101);
      chk("R8", "rand scl period", fall_t[2] - fall_t[1], 4 * dv);
      chk("R10", "rand irq", nirq, 1);
    end

    // random reads: R4 R6
    for (int t = 0; t < 10; t++) begin
      n = 1 + int'($urandom % 8);
      tg = 8'($urandom); dv = 12'(1 + $urandom % 3);
      for (int i = 0; i < 8; i++) src[i] = 8'($urandom);
      toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd3);
      for (int i = 0; i < n - 1; i++) toks = put(toks, 2 + i, 4'd4);
      toks = put(toks, 1 + n, 4'd5); toks = put(toks, 2 + n, 4'd6);
      run(toks, 64'h0, tg, dv, 1'b0);
      chk("R4", "rand read address", rxb[0], {tg[7:1], 1'b1});
      chk("R6", "rand ack count", nmack, n);
      for (int k = 0; k < n; k++) chk("R6", "rand ack bit", mack[k], (k == n - 1) ? 1 : 0);
      rd(3'd6, d); rd(3'd7, d2); rdw = {d2, d};
      for (int k = 0; k < n; k++) chk("R6", "rand read byte", rdw[k*8 +: 8], src[k]);
      chk("R9", "rand read stop", np, 1);
    end

    // R8 upper divider field, then R11 abort
    toks = '0; toks = put(toks, 0, 4'd1); toks = put(toks, 1, 4'd2);
    toks = put(toks, 2, 4'd4); toks = put(toks, 3, 4'd6);
    load(toks, wdat, 8'h66);
    wr(3'd0, ctrlw(12'h400, 1'b0, 1'b0));
    clear_log();
    wr(3'd0, ctrlw(12'h400, 1'b0, 1'b1));
    for (int i = 0; i < 20000 && nfall < 3; i++) @(negedge clk);
    chk("R8", "high divider period", fall_t[2] - fall_t[1], 4096);
    wr(3'd0, ctrlw(12'h400, 1'b0, 1'b0));
    chk("R11", "abort lines", {scl_oe, sda_oe}, 0);
    repeat (2) @(negedge clk);
    chk("R10", "abort irq", nirq, 1);
    rd(3'd0, d); chk("R11", "abort status", d[2], 0);
    chk("R10", "irq single cycle", dbl_irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule